// File: doc/BRIEF.md
# Configurable Synchronous Serial Master

This block runs one full-duplex byte exchange at a time over a three-wire synchronous serial link. The block is the master. It drives the serial clock and the outgoing data line, and it samples the incoming data line. A small register port holds two locations: a mode byte and a transmit byte. The mode byte sets the bit order, the clock idle level, the clock phase and the clock rate. The transmit byte is the value sent on the next exchange.

A one-cycle start pulse begins an exchange. During the exchange, the serial clock makes sixteen edges. Each half period of the serial clock lasts 2^(7-rate) system clocks. When the last edge is made, busy drops, and a one-cycle done pulse presents the received byte on a parallel output.

Between exchanges, the serial clock rests at the idle level chosen by the mode byte.

Top module: `sync_serial_master`

## Requirements
- R1: The mode byte is at register address 0 and the transmit byte is at address 1. Mode bits 4 and 3 always read back as 0, whatever value was written. All other bits read back as written.
- R2: After reset, the mode byte reads 0, busy and done are low, the serial clock is high and the data output is low.
- R3: Mode bit 7 selects the bit order. With 0, bit 0 of the transmit byte goes out first. With 1, bit 7 goes out first. Received bits are placed in the matching order.
- R4: Mode bit 6 sets the clock idle level. With 0, the serial clock idles high. With 1, it idles low. The clock rests at this level whenever no exchange is running.
- R5: Mode bit 5 sets the clock phase.
  - With 0, output data changes on the first edge of each bit period and input data is latched on the second edge.
  - With 1, input data is latched on the first edge of each bit period and output data changes on the second edge.
- R6: Mode bits 2..0 select the rate.
  - The codes 000 to 110 give one serial clock period of 256, 128, 64, 32, 16, 8 and 4 system clocks, in that order.
  - The code 111 gives a period of 2 system clocks.
  - An exchange lasts exactly 16 half periods, from the start pulse to done.
- R7: Busy rises in the cycle after an accepted start pulse. Busy falls at the sixteenth serial clock edge. Done is high for exactly that one cycle.
- R8: While busy is high, writes to the mode byte are ignored and start pulses are ignored.
- R9: With phase 1, the first data bit is on the data output in the cycle after the start pulse, before the first clock edge.
- R10: The received byte presented with done holds the eight bits sampled from the input line, placed according to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 selects the mode byte, 1 selects the transmit byte |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| start | input | 1 | One-cycle pulse that begins an exchange |
| sdi | input | 1 | Serial data input |
| busy | output | 1 | High while an exchange is running |
| done | output | 1 | One-cycle pulse when the exchange ends |
| rxData | output | 8 | Byte received in the last exchange |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data output |

## Verification
The checker watches the control sequence on every cycle:
- the done pulse lasts one cycle and coincides with the fall of busy;
- busy rises only after a start pulse;
- the mode byte stays frozen while busy is high;
- the reserved mode bits stay zero;
- the serial clock sits at the idle level whenever the block is idle.

Only the bench's scenarios can show the data behaviour. A bench slave follows the clock edges, checks each outgoing bit at its latch edge and feeds incoming bits at the change edges. Together with the measured exchange length, this covers bit order, both phases, the first-bit setup and every rate code.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  // Per-cycle strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;      // accepted start: copy transmit byte into shifter
    logic tick;      // serial clock edge this cycle
    logic sample;    // capture sdi at this edge
    logic shiftOut;  // advance outgoing bit at this edge
    logic finish;    // last edge of the exchange
  } ssmStrobe_t;
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              phaseLatchFirst,
  input  logic [RATE_W-1:0] rateSel,
  output logic              busy,
  output logic              done,
  output ssmStrobe_t        strb
);
  localparam int MAX_SH    = (1 << RATE_W) - 1;
  localparam int CNT_W     = MAX_SH;
  localparam int EDGES     = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);
  localparam logic [CNT_W:0]    ONE       = (CNT_W + 1)'(1);

  logic [CNT_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic [CNT_W:0]    halfLen;
  logic              tickNow, leading, lastEdge;

  // half period in system clocks: 2^(MAX_SH - rateSel)
  assign halfLen  = ONE << (RATE_W'(MAX_SH) - rateSel);
  assign tickNow  = busy && ({1'b0, divCnt} == (halfLen - ONE));
  assign leading  = ~edgeIdx[0];
  assign lastEdge = (edgeIdx == LAST_EDGE);

  always_comb begin
    strb.load     = start & ~busy;
    strb.tick     = tickNow;
    strb.sample   = tickNow & (phaseLatchFirst ? leading : ~leading);
    strb.shiftOut = tickNow & (phaseLatchFirst ? ~leading
                                               : (leading & (edgeIdx != '0)));
    strb.finish   = tickNow & lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      divCnt  <= '0;
      edgeIdx <= '0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        edgeIdx <= '0;
      end else if (busy) begin
        if (tickNow) begin
          divCnt  <= '0;
          edgeIdx <= edgeIdx + 1'b1;
          if (lastEdge) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssmStrobe_t        strb,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              phaseLatchFirst,
  output logic [RATE_W-1:0] rateSel,
  output logic [REG_W-1:0]  modeBits
);
  localparam int ORDER_BIT = REG_W - 1;
  localparam int POL_BIT   = REG_W - 2;
  localparam int PHASE_BIT = REG_W - 3;
  localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(2'b11) << RATE_W;
  localparam logic [REG_W-1:0] WR_MASK   = ~RSVD_MASK;
  localparam logic ADDR_MODE = 1'b0;

  logic [REG_W-1:0]  modeReg;
  logic [DATA_W-1:0] txHold, txShift, rxShift, rxNext;
  logic              msbFirst, sclkReg;

  assign msbFirst        = modeReg[ORDER_BIT];
  assign phaseLatchFirst = modeReg[PHASE_BIT];
  assign rateSel         = modeReg[RATE_W-1:0];
  assign modeBits        = modeReg;
  assign regRdData       = (regAddr == ADDR_MODE) ? modeReg : REG_W'(txHold);
  assign sclk            = sclkReg;
  assign sdo             = msbFirst ? txShift[DATA_W-1] : txShift[0];

  always_comb begin
    rxNext = rxShift;
    if (strb.sample)
      rxNext = msbFirst ? {rxShift[DATA_W-2:0], sdi} : {sdi, rxShift[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      sclkReg <= 1'b1;
    end else begin
      if (regWrEn && regAddr == ADDR_MODE && !busy && !strb.load)
        modeReg <= regWrData & WR_MASK;
      if (regWrEn && regAddr != ADDR_MODE)
        txHold <= regWrData[DATA_W-1:0];

      if (strb.load)
        txShift <= txHold;
      else if (strb.shiftOut)
        txShift <= msbFirst ? {txShift[DATA_W-2:0], 1'b0} : {1'b0, txShift[DATA_W-1:1]};

      rxShift <= rxNext;
      if (strb.finish) rxData <= rxNext;

      if (!busy)          sclkReg <= ~modeReg[POL_BIT];
      else if (strb.tick) sclkReg <= ~sclkReg;
    end
  end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       start,
  input  logic       sdi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rxData,
  output logic       sclk,
  output logic       sdo
);
  localparam int DATA_W = 8;
  localparam int RATE_W = 3;
  localparam int REG_W  = 8;

  ssmStrobe_t        strb;
  logic              phaseLatchFirst;
  logic [RATE_W-1:0] rateSel;
  logic [REG_W-1:0]  modeBits;

  ssm_ctrl #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .phaseLatchFirst(phaseLatchFirst), .rateSel(rateSel),
    .busy(busy), .done(done), .strb(strb)
  );

  ssm_datapath #(.DATA_W(DATA_W), .RATE_W(RATE_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sdi(sdi), .sclk(sclk), .sdo(sdo),
    .rxData(rxData), .phaseLatchFirst(phaseLatchFirst),
    .rateSel(rateSel), .modeBits(modeBits)
  );
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sclk,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [7:0] modeBits
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == 1'b0) |=> $stable(modeBits));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeBits[4:3] == 2'b00);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $stable(modeBits)) |-> sclk == ~modeBits[6]);
endmodule

bind sync_serial_master ssm_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .regWrEn(regWrEn), .regAddr(regAddr), .modeBits(modeBits)
);

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic start = 1'b0;
  logic sdi = 1'b0;
  logic busy, done, sclk, sdo;
  logic [7:0] rxData;

  int total = 0;
  int bad = 0;
  int wdog = 0;

  always #2 clk = ~clk;

  sync_serial_master u_sync_serial_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .start(start), .sdi(sdi),
    .busy(busy), .done(done), .rxData(rxData), .sclk(sclk), .sdo(sdo)
  );

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=190000", wdog);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic bitAt(input logic [7:0] b, input int k, input logic msb);
    return msb ? b[7-k] : b[k];
  endfunction

  function automatic int expHalf(input logic [2:0] sel);
    return 1 << (7 - sel);
  endfunction

  function automatic logic [7:0] expMode(input logic [7:0] w);
    return w & 8'hE7;
  endfunction

  task automatic writeReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic runXfer(input logic [7:0] mode, input logic [7:0] tx,
                         input logic [7:0] sIn, input bit disturb);
    logic msb, ph, idleLvl, prev;
    logic [7:0] rd;
    int half, cyc, edges;
    msb = mode[7]; ph = mode[5]; idleLvl = ~mode[6];
    half = expHalf(mode[2:0]);
    writeReg(1'b0, mode);
    writeReg(1'b1, tx);
    @(negedge clk);
    check(sclk == idleLvl, "R4 idle level", sclk, idleLvl);
    if (ph) sdi = bitAt(sIn, 0, msb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy rise", busy, 1);
    if (ph) check(sdo == bitAt(tx, 0, msb), "R9 first bit early", sdo, bitAt(tx, 0, msb));
    prev = sclk; cyc = 0; edges = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        regWrEn = 1'b1; regAddr = 1'b0; regWrData = ~mode; start = 1'b1;
      end
      if (disturb && cyc == 3) begin
        regWrEn = 1'b0; start = 1'b0;
      end
      if (sclk != prev) begin
        edges++;
        prev = sclk;
        if (ph ? (edges % 2 == 1) : (edges % 2 == 0)) begin
          int k;
          k = ph ? (edges - 1) / 2 : edges / 2 - 1;
          check(sdo == bitAt(tx, k, msb), "R3/R5 sdo bit", sdo, bitAt(tx, k, msb));
        end
        if (!ph && (edges % 2 == 1)) sdi = bitAt(sIn, (edges - 1) / 2, msb);
        if (ph && (edges % 2 == 0) && edges < 16) sdi = bitAt(sIn, edges / 2, msb);
      end
      if (done || cyc >= 5000) break;
    end
    check(cyc == 16 * half, "R6 length", cyc, 16 * half);
    check(edges == 16, "R6 edge count", edges, 16);
    check(busy == 1'b0, "R7 busy fall", busy, 0);
    check(rxData == sIn, "R10 rx byte", rxData, sIn);
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
    check(sclk == idleLvl, "R4 idle after", sclk, idleLvl);
    if (disturb) begin
      readReg(1'b0, rd);
      check(rd == expMode(mode), "R8 mode frozen", rd, expMode(mode));
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R8 start ignored", busy, 0);
    end
  endtask

  initial begin
    logic [7:0] rd;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    readReg(1'b0, rd);
    check(rd == 8'h00, "R2 mode reset", rd, 0);
    check(busy == 0 && done == 0, "R2 busy/done reset", {busy, done}, 0);
    check(sclk == 1'b1, "R2 sclk reset", sclk, 1);
    check(sdo == 1'b0, "R2 sdo reset", sdo, 0);
    // R1 reserved bits
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, rd);
    check(rd == 8'hE7, "R1 reserved read", rd, 8'hE7);
    writeReg(1'b0, 8'h18);
    readReg(1'b0, rd);
    check(rd == 8'h00, "R1 reserved only", rd, 0);
    writeReg(1'b1, 8'h5A);
    readReg(1'b1, rd);
    check(rd == 8'h5A, "R1 tx readback", rd, 8'h5A);
    // R6 every rate code, with varied order/polarity/phase
    for (int s = 0; s < 8; s++)
      runXfer({s[0], s[1], s[2], 2'b00, 3'(s)}, 8'hA5 ^ 8'(s), 8'h3C + 8'(s), 1'b0);
    // R3/R5 corner patterns at the fastest rate
    runXfer(8'h87, 8'h01, 8'h80, 1'b0);
    runXfer(8'h27, 8'h80, 8'h01, 1'b0);
    runXfer(8'hE7, 8'hFF, 8'h00, 1'b0);
    runXfer(8'h07, 8'h00, 8'hFF, 1'b0);
    // R8 disturbance during an exchange
    runXfer(8'h26, 8'hC3, 8'h96, 1'b1);
    runXfer(8'hC4, 8'h3C, 8'h69, 1'b1);
    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m[2:0] < 3'd2) m[2:0] = 3'd4;
      runXfer(m, 8'($urandom), 8'($urandom), (i % 5) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule